// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command writes a host issues to a flash-style memory and decides what a read returns. The host drives active-low chip enable, output enable and write enable, plus a power-down line, a write-protect line and a flag that says whether the programming supply is valid. All of these are sampled in one synchronous clock domain. A write completes when the host releases the bus after a cycle with chip enable and write enable both low. The command then takes effect on the first clock edge where the write is no longer active.

Single-write commands switch the read source between the memory array, the identifier codes and the status byte, or clear the status errors. Two-write sequences start a block erase or a word program. These run in a small write engine whose busy time is counted in clock cycles. The engine can be suspended and resumed. A small behavioural array model is built in, so reads of the array show the effect of each erase and program. The block at index `BOOT_BLK` is the boot block. Write protect can lock it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, or after power-down is released, reads return the array. Every array word reads 0xFFFF. The status byte reads 0x80, which means ready with no error and no suspend. Status bits: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 supply lockout, 2 program suspended. Bits 1:0 and 15:8 read 0.
- R2: A write of 0xFF in the low data byte selects array reads. It takes one write and is ignored while an operation runs unsuspended.
- R3: A write of 0x90 selects identifier reads. Address 0 returns `MFR_ID`, address 1 returns `DEV_ID`, and any other address returns 0.
- R4: A write of 0x70 selects status reads. A write of 0x50 clears bits 5, 4 and 3 of the status byte; they are sticky until then.
- R5: A write of 0x20 followed by a write of 0xD0 to an address in the same block erases that block to 0xFFFF. The erase takes `ERASE_CYC` clock cycles from the confirming write, and status is selected for reads.
- R6: A write of 0x40 or 0x10 followed by a second write programs the word at the second write's address. The new word is the old word AND the written data. The program takes `PROG_CYC` cycles.
- R7: If the second write of an erase sequence is not 0xD0, or goes to a different block, nothing is erased. Status bits 5 and 4 are set and status is selected for reads.
- R8: A write of 0xB0 while an operation runs suspends it. Ready reads 1 and bit 6 (erase) or bit 2 (program) is set. The remaining time is frozen, array reads may be selected, and a write of 0xD0 resumes the operation.
- R9: With the supply flag low, an erase sets bits 5 and 3 and a program sets bits 4 and 3. The array is not changed and reads still work.
- R10: With write protect low, an erase or program aimed at the boot block is refused. Erase sets bit 5 and program sets bit 4. Other blocks are unaffected.
- R11: While power-down is low, the data output is not driven (`dout_en` is 0). The command state, the errors and any running operation are reset, and the array contents are kept.
- R12: The address and data of a write are those present in the last cycle with chip enable and write enable both low. Output enable and write enable are never low together.
- R13: While an operation runs unsuspended, status bit 7 reads 0. Every command except 0xB0 and 0x70 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_n | input | 1 | Power-down, active low |
| wp_n | input | 1 | Boot block write protect, active low |
| vpp_ok | input | 1 | Programming supply valid |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| dout | output | DW | Read data, zero when not driven |
| dout_en | output | 1 | Output drive enable (low means high impedance) |

## Verification
The bench builds the block with `ERASE_CYC` = 30 and `PROG_CYC` = 12, and keeps the default geometry of four 16-word blocks. These short busy windows leave room to read status mid-operation, to issue ignored commands and to suspend and resume both an erase and a program within a few hundred cycles. With only four blocks, the boot block, a wrong-block confirm and erases that must leave neighbouring blocks intact are all exercised on a small array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_PROG  = 2'd2
  } seq_e;

  localparam logic [7:0] OP_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROG_A  = 8'h40;
  localparam logic [7:0] OP_PROG_B  = 8'h10;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

endpackage

// File: rtl/fc_bus_capture.sv
module fc_bus_capture #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  logic          act;
  logic          act_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = !ce_n && !we_n && pwr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (act) begin
      addr_q <= addr;
      data_q <= din;
    end
  end

  assign wr_evt  = act_q && !act;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

endmodule

// File: rtl/fc_cmd_decode.sv
module fc_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int BW       = 2,
  parameter int BOOT_BLK = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          wp_n,
  input  logic          vpp_ok,
  input  logic          wr_evt,
  input  logic [BW-1:0] wr_blk,
  input  logic [7:0]    wr_cmd,
  input  logic          busy,
  input  logic          susp,
  output rd_mode_e      rd_mode,
  output logic          err_ers,
  output logic          err_prg,
  output logic          err_vpp,
  output logic          start_ers,
  output logic          start_prg,
  output logic          sus_req,
  output logic          res_req,
  output logic          clr_req
);

  localparam logic [BW-1:0] BOOT = BOOT_BLK[BW-1:0];

  rd_mode_e      mode_q, mode_n;
  seq_e          seq_q, seq_n;
  logic [BW-1:0] blk_q, blk_n;
  logic          ers_q, ers_n, prg_q, prg_n, vpp_q, vpp_n;
  logic          locked;

  assign locked = (wr_blk == BOOT) && !wp_n;

  always_comb begin
    mode_n    = mode_q;
    seq_n     = seq_q;
    blk_n     = blk_q;
    ers_n     = ers_q;
    prg_n     = prg_q;
    vpp_n     = vpp_q;
    start_ers = 1'b0;
    start_prg = 1'b0;
    sus_req   = 1'b0;
    res_req   = 1'b0;
    clr_req   = 1'b0;
    if (wr_evt && pwr_n) begin
      unique case (seq_q)
        SEQ_ERASE: begin
          seq_n  = SEQ_IDLE;
          mode_n = RD_STATUS;
          if (wr_cmd == OP_CONFIRM && wr_blk == blk_q) begin
            if (!vpp_ok) begin
              vpp_n = 1'b1;
              ers_n = 1'b1;
            end else if (locked) begin
              ers_n = 1'b1;
            end else begin
              start_ers = 1'b1;
            end
          end else begin
            ers_n = 1'b1;
            prg_n = 1'b1;
          end
        end
        SEQ_PROG: begin
          seq_n  = SEQ_IDLE;
          mode_n = RD_STATUS;
          if (!vpp_ok) begin
            vpp_n = 1'b1;
            prg_n = 1'b1;
          end else if (locked) begin
            prg_n = 1'b1;
          end else begin
            start_prg = 1'b1;
          end
        end
        default: begin
          if (busy && !susp) begin
            if (wr_cmd == OP_SUSPEND) begin
              sus_req = 1'b1;
              mode_n  = RD_STATUS;
            end else if (wr_cmd == OP_STATUS) begin
              mode_n = RD_STATUS;
            end
          end else begin
            case (wr_cmd)
              OP_ARRAY:  mode_n = RD_ARRAY;
              OP_IDENT:  mode_n = RD_IDENT;
              OP_STATUS: mode_n = RD_STATUS;
              OP_CLEAR: begin
                clr_req = 1'b1;
                ers_n   = 1'b0;
                prg_n   = 1'b0;
                vpp_n   = 1'b0;
              end
              OP_CONFIRM: begin
                if (susp) begin
                  res_req = 1'b1;
                  mode_n  = RD_STATUS;
                end
              end
              OP_ERASE: begin
                if (!susp) begin
                  seq_n  = SEQ_ERASE;
                  blk_n  = wr_blk;
                  mode_n = RD_STATUS;
                end
              end
              OP_PROG_A, OP_PROG_B: begin
                if (!susp) begin
                  seq_n  = SEQ_PROG;
                  mode_n = RD_STATUS;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RD_ARRAY;
      seq_q  <= SEQ_IDLE;
      blk_q  <= '0;
      ers_q  <= 1'b0;
      prg_q  <= 1'b0;
      vpp_q  <= 1'b0;
    end else if (!pwr_n) begin
      mode_q <= RD_ARRAY;
      seq_q  <= SEQ_IDLE;
      blk_q  <= '0;
      ers_q  <= 1'b0;
      prg_q  <= 1'b0;
      vpp_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      seq_q  <= seq_n;
      blk_q  <= blk_n;
      ers_q  <= ers_n;
      prg_q  <= prg_n;
      vpp_q  <= vpp_n;
    end
  end

  assign rd_mode = mode_q;
  assign err_ers = ers_q;
  assign err_prg = prg_q;
  assign err_vpp = vpp_q;

endmodule

// File: rtl/fc_wsm.sv
module fc_wsm #(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int ERASE_CYC = 64,
  parameter int PROG_CYC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_n,
  input  logic          start_ers,
  input  logic          start_prg,
  input  logic          sus_req,
  input  logic          res_req,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  output logic          busy,
  output logic          susp,
  output logic          is_ers,
  output logic          mem_we,
  output logic          mem_erase,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data
);

  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic             busy_q, busy_n, susp_q, susp_n, ers_q, ers_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic [DW-1:0]    data_q, data_n;
  logic             run, done;

  assign run  = busy_q && !susp_q && !sus_req;
  assign done = run && (cnt_q == CNT_W'(1));

  always_comb begin
    busy_n = busy_q;
    susp_n = susp_q;
    ers_n  = ers_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    data_n = data_q;
    if (start_ers || start_prg) begin
      busy_n = 1'b1;
      susp_n = 1'b0;
      ers_n  = start_ers;
      cnt_n  = start_ers ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
      addr_n = op_addr;
      data_n = op_data;
    end else if (sus_req) begin
      susp_n = 1'b1;
    end else if (res_req) begin
      susp_n = 1'b0;
    end else if (done) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (run) begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      ers_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!pwr_n) begin
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      ers_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      susp_q <= susp_n;
      ers_q  <= ers_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign busy      = busy_q;
  assign susp      = susp_q;
  assign is_ers    = ers_q;
  assign mem_we    = done && pwr_n;
  assign mem_erase = ers_q;
  assign mem_addr  = addr_q;
  assign mem_data  = data_q;

endmodule

// File: rtl/fc_array_model.sv
module fc_array_model #(
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int BLK_AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          erase,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] rd_vec [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    localparam logic [AW-1:0] WA = AW'(g);
    logic [DW-1:0] word_q;
    logic          hit;

    assign hit = erase ? (waddr[AW-1:BLK_AW] == WA[AW-1:BLK_AW]) : (waddr == WA);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (we && hit) begin
        word_q <= erase ? '1 : (word_q & wdata);
      end
    end

    assign rd_vec[g] = word_q;
  end

  assign rdata = rd_vec[raddr];

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 16,
  parameter int          BLK_AW    = 4,
  parameter int          BOOT_BLK  = 0,
  parameter int          ERASE_CYC = 64,
  parameter int          PROG_CYC  = 8,
  parameter logic [15:0] MFR_ID    = 16'h00A7,
  parameter logic [15:0] DEV_ID    = 16'h0053
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pwr_n,
  input  logic          wp_n,
  input  logic          vpp_ok,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en
);

  localparam int BW = AW - BLK_AW;

  logic          rst_meta, rst_s;
  logic          wr_evt;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  rd_mode_e      rd_mode;
  logic          err_ers, err_prg, err_vpp;
  logic          start_ers, start_prg, start_any, sus_req, res_req, clr_req;
  logic          busy, susp, is_ers;
  logic          mem_we, mem_erase;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data, arr_rdata;
  logic [7:0]    stat_byte;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  fc_bus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk     (clk),
    .rst_n   (rst_s),
    .pwr_n   (pwr_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (addr),
    .din     (din),
    .wr_evt  (wr_evt),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  fc_cmd_decode #(.BW(BW), .BOOT_BLK(BOOT_BLK)) u_dec (
    .clk       (clk),
    .rst_n     (rst_s),
    .pwr_n     (pwr_n),
    .wp_n      (wp_n),
    .vpp_ok    (vpp_ok),
    .wr_evt    (wr_evt),
    .wr_blk    (wr_addr[AW-1:BLK_AW]),
    .wr_cmd    (wr_data[7:0]),
    .busy      (busy),
    .susp      (susp),
    .rd_mode   (rd_mode),
    .err_ers   (err_ers),
    .err_prg   (err_prg),
    .err_vpp   (err_vpp),
    .start_ers (start_ers),
    .start_prg (start_prg),
    .sus_req   (sus_req),
    .res_req   (res_req),
    .clr_req   (clr_req)
  );

  fc_wsm #(.AW(AW), .DW(DW), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_wsm (
    .clk       (clk),
    .rst_n     (rst_s),
    .pwr_n     (pwr_n),
    .start_ers (start_ers),
    .start_prg (start_prg),
    .sus_req   (sus_req),
    .res_req   (res_req),
    .op_addr   (wr_addr),
    .op_data   (wr_data),
    .busy      (busy),
    .susp      (susp),
    .is_ers    (is_ers),
    .mem_we    (mem_we),
    .mem_erase (mem_erase),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
  );

  fc_array_model #(.AW(AW), .DW(DW), .BLK_AW(BLK_AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (mem_we),
    .erase (mem_erase),
    .waddr (mem_addr),
    .wdata (mem_data),
    .raddr (addr),
    .rdata (arr_rdata)
  );

  assign start_any = start_ers || start_prg;

  assign stat_byte = {(!busy || susp), (susp && is_ers), err_ers, err_prg,
                      err_vpp, (susp && !is_ers), 2'b00};

  always_comb begin
    unique case (rd_mode)
      RD_IDENT: begin
        if (addr == AW'(0))      rd_word = DW'(MFR_ID);
        else if (addr == AW'(1)) rd_word = DW'(DEV_ID);
        else                     rd_word = '0;
      end
      RD_STATUS: rd_word = DW'(stat_byte);
      default:   rd_word = arr_rdata;
    endcase
  end

  assign dout_en = pwr_n && !ce_n && !oe_n;
  assign dout    = dout_en ? rd_word : '0;

endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       dout_en,
  input logic       busy,
  input logic       susp,
  input logic       start_any,
  input logic       clr_req,
  input logic [7:0] stat_byte
);

  a_r11_pd_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |-> !dout_en);

  a_r8_susp_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    susp |-> busy);

  a_r13_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |-> !busy);

  a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_any));

  a_r4_clear_empties_errors: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (stat_byte[5:3] == 3'b000));

  a_r12_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !oe_n && !we_n));

endmodule

bind flash_cmd_ctrl fc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_n     (pwr_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dout_en   (dout_en),
  .busy      (busy),
  .susp      (susp),
  .start_any (start_any),
  .clr_req   (clr_req),
  .stat_byte (stat_byte)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

  localparam int          AW   = 6;
  localparam int          DW   = 16;
  localparam int          ECYC = 30;
  localparam int          PCYC = 12;
  localparam logic [15:0] MFR  = 16'h00A7;
  localparam logic [15:0] DEV  = 16'h0053;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          pwr_n = 1'b1, wp_n = 1'b1, vpp_ok = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(
    .AW(AW), .DW(DW), .BLK_AW(4), .BOOT_BLK(0),
    .ERASE_CYC(ECYC), .PROG_CYC(PCYC), .MFR_ID(MFR), .DEV_ID(DEV)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_n(pwr_n), .wp_n(wp_n), .vpp_ok(vpp_ok), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  // ---------------- behavioural reference model ----------------
  bit          r1, r2;
  int          m_mode;            // 0 array, 1 ident, 2 status
  int          m_seq;             // 0 idle, 1 erase setup, 2 program setup
  int          m_sblk;
  bit          m_eers, m_eprg, m_evpp;
  bit          m_busy, m_susp, m_ers;
  int          m_cnt;
  int          m_waddr;
  logic [15:0] m_wdata;
  logic [15:0] mm [64];
  bit          prev_act;
  int          cap_addr;
  logic [15:0] cap_data;

  function automatic logic [7:0] m_status();
    return {(!m_busy || m_susp), (m_susp && m_ers), m_eers, m_eprg, m_evpp,
            (m_susp && !m_ers), 2'b00};
  endfunction

  function automatic logic [15:0] m_expect();
    if (!(pwr_n && !ce_n && !oe_n)) return 16'h0000;
    if (m_mode == 1) return (addr == 0) ? MFR : ((addr == 1) ? DEV : 16'h0000);
    if (m_mode == 2) return {8'h00, m_status()};
    return mm[addr];
  endfunction

  task automatic m_clear_cmd();
    m_mode = 0; m_seq = 0; m_sblk = 0;
    m_eers = 0; m_eprg = 0; m_evpp = 0;
    m_busy = 0; m_susp = 0; m_ers = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    bit act, ev, st_e, st_p, sus, res, ob, os, lockd;
    logic [7:0] c;
    int blk;
    if (!rst_n) begin r1 = 0; r2 = 0; end
    if (!rst_n || !r2) begin
      m_clear_cmd();
      for (int i = 0; i < 64; i++) mm[i] = 16'hFFFF;
      prev_act = 0; cap_addr = 0; cap_data = 0;
      m_waddr = 0; m_wdata = 0;
      if (rst_n) begin r2 = r1; r1 = 1; end
    end else begin
      act = !ce_n && !we_n && pwr_n;
      ev  = prev_act && !act;
      st_e = 0; st_p = 0; sus = 0; res = 0;
      ob = m_busy; os = m_susp;
      if (!pwr_n) begin
        m_clear_cmd();
      end else begin
        c = cap_data[7:0];
        blk = cap_addr / 16;
        lockd = (blk == 0) && !wp_n;
        if (ev) begin
          if (m_seq == 1) begin
            m_seq = 0; m_mode = 2;
            if (c == 8'hD0 && blk == m_sblk) begin
              if (!vpp_ok) begin m_evpp = 1; m_eers = 1; end
              else if (lockd) m_eers = 1;
              else st_e = 1;
            end else begin m_eers = 1; m_eprg = 1; end
          end else if (m_seq == 2) begin
            m_seq = 0; m_mode = 2;
            if (!vpp_ok) begin m_evpp = 1; m_eprg = 1; end
            else if (lockd) m_eprg = 1;
            else st_p = 1;
          end else if (ob && !os) begin
            if (c == 8'hB0) begin sus = 1; m_mode = 2; end
            else if (c == 8'h70) m_mode = 2;
          end else begin
            case (c)
              8'hFF: m_mode = 0;
              8'h90: m_mode = 1;
              8'h70: m_mode = 2;
              8'h50: begin m_eers = 0; m_eprg = 0; m_evpp = 0; end
              8'hD0: if (os) begin res = 1; m_mode = 2; end
              8'h20: if (!os) begin m_seq = 1; m_sblk = blk; m_mode = 2; end
              8'h40, 8'h10: if (!os) begin m_seq = 2; m_mode = 2; end
              default: ;
            endcase
          end
        end
        if (st_e || st_p) begin
          m_busy = 1; m_susp = 0; m_ers = st_e;
          m_cnt = st_e ? ECYC : PCYC;
          m_waddr = cap_addr; m_wdata = cap_data;
        end else if (sus) begin
          m_susp = 1;
        end else if (res) begin
          m_susp = 0;
        end else if (ob && !os) begin
          if (m_cnt == 1) begin
            m_busy = 0; m_cnt = 0;
            if (m_ers) begin
              for (int i = 0; i < 64; i++) if (i / 16 == m_waddr / 16) mm[i] = 16'hFFFF;
            end else begin
              mm[m_waddr] = mm[m_waddr] & m_wdata;
            end
          end else begin
            m_cnt = m_cnt - 1;
          end
        end
      end
      if (act) begin cap_addr = addr; cap_data = din; end
      prev_act = act;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && r2 && !done_flag) begin
      logic [15:0] e;
      e = m_expect();
      checks++;
      if (dout !== e || dout_en !== (pwr_n && !ce_n && !oe_n)) begin
        errors++;
        $display("FAIL %s model compare: dout=%h en=%b expected dout=%h en=%b",
                 (m_mode == 2) ? "R4" : ((m_mode == 1) ? "R3" : "R2"),
                 dout, dout_en, e, (pwr_n && !ce_n && !oe_n));
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    ce_n = 0; we_n = 0; addr = a; din = d;
    @(posedge clk); @(posedge clk); #1;
    we_n = 1; ce_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk);
    chk(tag, dout, exp);
    @(posedge clk); #1;
    ce_n = 1; oe_n = 1;
  endtask

  initial begin
    idle(4);
    rst_n = 1;
    idle(4);

    // R1 reset state
    rd(6'h05, 16'hFFFF, "R1 array after reset");
    wr(6'h00, 16'h0070);
    rd(6'h00, 16'h0080, "R1 status after reset");

    // R3 identifier reads
    wr(6'h00, 16'h0090);
    rd(6'h00, MFR, "R3 manufacturer code");
    rd(6'h01, DEV, "R3 device code");
    rd(6'h02, 16'h0000, "R3 other id address");

    // R2 back to array
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'hFFFF, "R2 array read");

    // R6/R13 program with 0x40
    wr(6'h15, 16'h0040);
    wr(6'h15, 16'h1234);
    rd(6'h00, 16'h0000, "R13 ready low while programming");
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'h0000, "R13 array command ignored while busy");
    idle(PCYC + 2);
    rd(6'h00, 16'h0080, "R6 ready after program");
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'h1234, "R6 programmed word");
    wr(6'h16, 16'h0010);
    wr(6'h16, 16'h00F0);
    idle(PCYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h16, 16'h00F0, "R6 program via 0x10 setup");
    wr(6'h15, 16'h0040);
    wr(6'h15, 16'hFF0F);
    idle(PCYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'h1204, "R6 program ANDs data");

    // R5/R8 erase with suspend and resume
    wr(6'h10, 16'h0020);
    wr(6'h1A, 16'h00D0);
    rd(6'h00, 16'h0000, "R5 erase busy");
    wr(6'h00, 16'h00B0);
    rd(6'h00, 16'h00C0, "R8 erase suspended status");
    idle(ECYC + 10);
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'h1204, "R8 array readable while suspended");
    wr(6'h00, 16'h00D0);
    rd(6'h00, 16'h0000, "R8 resumed busy");
    idle(ECYC + 2);
    rd(6'h00, 16'h0080, "R5 erase done");
    wr(6'h00, 16'h00FF);
    rd(6'h15, 16'hFFFF, "R5 block erased");
    rd(6'h16, 16'hFFFF, "R5 block erased second word");

    // R8 program suspend
    wr(6'h30, 16'h0040);
    wr(6'h30, 16'h0F0F);
    wr(6'h00, 16'h00B0);
    rd(6'h00, 16'h0084, "R8 program suspended status");
    idle(PCYC + 4);
    rd(6'h00, 16'h0084, "R8 program stays suspended");
    wr(6'h00, 16'h00D0);
    idle(PCYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h30, 16'h0F0F, "R8 program completes after resume");

    // R7 bad confirm code and wrong block
    wr(6'h20, 16'h0020);
    wr(6'h20, 16'h00FF);
    rd(6'h00, 16'h00B0, "R7 wrong confirm code");
    wr(6'h00, 16'h0050);
    rd(6'h00, 16'h0080, "R4 clear status");
    wr(6'h30, 16'h0020);
    wr(6'h05, 16'h00D0);
    rd(6'h00, 16'h00B0, "R7 confirm to other block");
    idle(ECYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h30, 16'h0F0F, "R7 nothing erased");
    wr(6'h00, 16'h0050);

    // R9 supply lockout
    vpp_ok = 0;
    wr(6'h31, 16'h0040);
    wr(6'h31, 16'h0000);
    rd(6'h00, 16'h0098, "R9 program under lockout");
    wr(6'h00, 16'h0050);
    wr(6'h30, 16'h0020);
    wr(6'h30, 16'h00D0);
    rd(6'h00, 16'h00A8, "R9 erase under lockout");
    wr(6'h00, 16'h00FF);
    rd(6'h31, 16'hFFFF, "R9 word unchanged");
    rd(6'h30, 16'h0F0F, "R9 reads still work");
    wr(6'h00, 16'h0050);
    vpp_ok = 1;

    // R10 boot block protection
    wp_n = 0;
    wr(6'h02, 16'h0040);
    wr(6'h02, 16'h0000);
    rd(6'h00, 16'h0090, "R10 boot block program refused");
    wr(6'h00, 16'h0050);
    wr(6'h03, 16'h0020);
    wr(6'h03, 16'h00D0);
    rd(6'h00, 16'h00A0, "R10 boot block erase refused");
    wr(6'h00, 16'h0050);
    wr(6'h32, 16'h0040);
    wr(6'h32, 16'h00AA);
    idle(PCYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h02, 16'hFFFF, "R10 boot word untouched");
    rd(6'h32, 16'h00AA, "R10 other block programs");
    wp_n = 1;
    wr(6'h02, 16'h0040);
    wr(6'h02, 16'h1111);
    idle(PCYC + 2);
    wr(6'h00, 16'h00FF);
    rd(6'h02, 16'h1111, "R10 boot programs when unprotected");

    // R12 capture at end of write
    wr(6'h33, 16'h0040);
    @(posedge clk); #1;
    ce_n = 0; we_n = 0; addr = 6'h33; din = 16'hAAAA;
    @(posedge clk); #1;
    addr = 6'h34; din = 16'h5555;
    @(posedge clk); #1;
    we_n = 1; ce_n = 1;
    idle(PCYC + 3);
    wr(6'h00, 16'h00FF);
    rd(6'h34, 16'h5555, "R12 last cycle address and data used");
    rd(6'h33, 16'hFFFF, "R12 earlier address not written");

    // R11 power-down
    wr(6'h00, 16'h0090);
    wr(6'h30, 16'h0020);
    wr(6'h30, 16'h00D0);
    @(posedge clk); #1;
    pwr_n = 0;
    ce_n = 0; oe_n = 0; addr = 6'h00;
    @(negedge clk);
    chk("R11 output not driven", {15'd0, dout_en}, 16'h0000);
    idle(3);
    ce_n = 1; oe_n = 1;
    pwr_n = 1;
    idle(2);
    rd(6'h34, 16'h5555, "R11 array mode and contents kept");
    wr(6'h00, 16'h0070);
    rd(6'h00, 16'h0080, "R11 operation aborted");

    idle(4);
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule